// File: doc/BRIEF.md
# Three-Group Encoded Interrupt Status

The block collects interrupt requests from three source groups (critical, main and peripheral) and condenses them into a single 32-bit status word. Each group has its own valid flag and its own encoded field in that word. The field names the winning request of the group. Within a group the lowest-numbered live request wins. A service routine reads the word and takes the first group whose flag is set, in the order critical, main, peripheral.

The main and peripheral groups each have a mask register in which a set bit disables a source. Each peripheral source also carries a 2-bit priority. A peripheral source at high or medium priority is reported through a reserved code in the critical or main field. The peripheral field then carries the number of the boosted source, so one read of the word still leads to the right source. A small register port gives read and write access to the masks and priorities, and read access to the status word. The status word is registered, so it follows the inputs by one clock.

Top module: `irq_status_enc`

## Requirements
- R1: After reset the main mask reads 0x00010fff, the peripheral mask reads 0x7ffffc00, both priority words read 0 and the status word is 0.
- R2: Critical requests are never masked. Status bit 10 flags a critical winner and bits 9:8 hold the lowest-numbered active critical source. Critical source 2 is ignored because code 2 is reserved.
- R3: Status bit 21 flags a main winner and bits 20:16 hold the lowest-numbered active unmasked main source. Main source 4 is ignored because code 4 is reserved.
- R4: Status bit 29 flags a peripheral winner and bits 28:24 hold its source number. The flag is set whenever any unmasked peripheral request is active.
- R5: Main source n is disabled by bit (16 - n) of the main mask, which sits at address 1. Only bits 16:0 are stored and the other bits read 0.
- R6: Peripheral source n is disabled by bit (31 - n) of the peripheral mask, which sits at address 2. A masked source cannot win any field, including through a boost. Only the bits of the existing sources (31:8 for 24 sources) are stored.
- R7: Peripheral source n has a 2-bit priority at bits 2(n mod 16)+1 : 2(n mod 16). Sources 0-15 are at address 3 and sources 16 and up at address 4. Code 1 is medium, code 2 is high, and codes 0 and 3 are normal.
- R8: An active unmasked high-priority peripheral source makes the critical field read code 2 with bit 10 set, provided no genuine critical request is active. A genuine critical request takes the field first.
- R9: An active unmasked medium-priority peripheral source makes the main field read code 4 with bit 21 set, provided no genuine main request and no high-priority peripheral request are active.
- R10: The peripheral field names the lowest-numbered high-priority source if there is one, else the lowest-numbered medium one, else the lowest-numbered normal one.
- R11: A group with no winner reads 0 in both its flag and its field. All status bits outside the three fields and flags are 0.
- R12: The status word reflects the requests and registers as they were sampled on the previous rising clock edge. A register write is therefore seen in the status one clock after it is written.
- R13: Address 0 returns the status word and ignores writes. Addresses 5 to 7 read 0 and ignore writes. Reads return data combinationally from the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 4 | Critical group requests |
| main_req_i | input | 17 | Main group requests |
| per_req_i | input | NUM_PER (24) | Peripheral group requests |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| status_o | output | 32 | Registered encoded status word |

## Verification
The bench goes after the reserved codes. A design that let critical source 2 or main source 4 through would show a boost code with no peripheral behind it. It also checks that a masked high-priority peripheral source cannot raise the critical field. A design that boosted before masking would report a source that software had disabled. The bench checks that priority code 3 stays normal and that a high source outranks a lower-numbered medium one in the peripheral field. A wrong order there sends the service routine to the wrong source. Reversed mask bit order and one-cycle timing after a register write are checked against the reference model on every clock.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CRIT_N   = 4;
  localparam int unsigned MAIN_N   = 17;
  localparam int unsigned PER_MAX  = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned PRI_W    = 2;
  localparam int unsigned PRI_PER_WORD = WORD_W / PRI_W;

  // status word layout, decoded by software
  localparam int unsigned CRIT_VLD = 10;
  localparam int unsigned CRIT_LSB = 8;
  localparam int unsigned CRIT_W   = 2;
  localparam int unsigned MAIN_VLD = 21;
  localparam int unsigned MAIN_LSB = 16;
  localparam int unsigned PER_VLD  = 29;
  localparam int unsigned PER_LSB  = 24;

  localparam int unsigned CRIT_BOOST = 2;
  localparam int unsigned MAIN_BOOST = 4;

  localparam int unsigned MAIN_MASK_TOP = 16;
  localparam int unsigned PER_MASK_TOP  = 31;
  localparam logic [WORD_W-1:0] MAIN_MASK_RST = 32'h0001_0fff;
  localparam logic [WORD_W-1:0] PER_MASK_RST  = 32'h7fff_fc00;

  typedef enum logic [PRI_W-1:0] {
    PRI_NORMAL = 2'd0,
    PRI_MEDIUM = 2'd1,
    PRI_HIGH   = 2'd2,
    PRI_RSVD   = 2'd3
  } pri_e;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS    = 3'd0,
    ADR_MAIN_MASK = 3'd1,
    ADR_PER_MASK  = 3'd2,
    ADR_PRI_BASE  = 3'd3
  } reg_sel_e;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } grp_t;

  function automatic logic [WORD_W-1:0] pack_status(grp_t c, grp_t m, grp_t p);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CRIT_VLD] = c.vld;
    w[CRIT_LSB +: CRIT_W] = c.idx[CRIT_W-1:0];
    w[MAIN_VLD] = m.vld;
    w[MAIN_LSB +: IDX_W] = m.idx;
    w[PER_VLD] = p.vld;
    w[PER_LSB +: IDX_W] = p.idx;
    return w;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned OUT_W = 5
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = OUT_W'(i);
    end
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_PER = 24
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [WORD_W-1:0]               wdata_i,
  input  logic [WORD_W-1:0]               status_i,
  output logic [WORD_W-1:0]               rdata_o,
  output logic [MAIN_N-1:0]               main_en_o,
  output logic [NUM_PER-1:0]              per_en_o,
  output logic [NUM_PER-1:0][PRI_W-1:0]   per_pri_o
);
  localparam int unsigned PER_MASK_LO = PER_MASK_TOP + 1 - NUM_PER;
  localparam int unsigned PRI_WORDS   = (NUM_PER + PRI_PER_WORD - 1) / PRI_PER_WORD;

  logic [MAIN_MASK_TOP:0]           main_mask_q;
  logic [PER_MASK_TOP:PER_MASK_LO]  per_mask_q;
  logic [PRI_W-1:0]                 pri_q [NUM_PER];
  logic [WORD_W-1:0]                pri_word [PRI_WORDS];
  logic [WORD_W-1:0]                per_mask_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_mask_q <= MAIN_MASK_RST[MAIN_MASK_TOP:0];
    end else if (we_i && addr_i == ADR_MAIN_MASK) begin
      main_mask_q <= wdata_i[MAIN_MASK_TOP:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_mask_q <= PER_MASK_RST[PER_MASK_TOP:PER_MASK_LO];
    end else if (we_i && addr_i == ADR_PER_MASK) begin
      per_mask_q <= wdata_i[PER_MASK_TOP:PER_MASK_LO];
    end
  end

  for (genvar n = 0; n < NUM_PER; n++) begin : g_pri
    localparam int unsigned WSEL = n / PRI_PER_WORD;
    localparam int unsigned SLOT = n % PRI_PER_WORD;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pri_q[n] <= PRI_NORMAL;
      end else if (we_i && addr_i == ADDR_W'(ADR_PRI_BASE) + ADDR_W'(WSEL)) begin
        pri_q[n] <= wdata_i[SLOT*PRI_W +: PRI_W];
      end
    end
    assign per_pri_o[n] = pri_q[n];
    assign per_en_o[n]  = ~per_mask_q[PER_MASK_TOP - n];
  end

  for (genvar n = 0; n < MAIN_N; n++) begin : g_main_en
    assign main_en_o[n] = ~main_mask_q[MAIN_MASK_TOP - n];
  end

  always_comb begin
    for (int w = 0; w < PRI_WORDS; w++) pri_word[w] = '0;
    for (int n = 0; n < NUM_PER; n++) begin
      pri_word[n / PRI_PER_WORD][(n % PRI_PER_WORD)*PRI_W +: PRI_W] = pri_q[n];
    end
  end

  always_comb begin
    per_mask_rd = '0;
    per_mask_rd[PER_MASK_TOP:PER_MASK_LO] = per_mask_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_STATUS)    rdata_o = status_i;
    if (addr_i == ADR_MAIN_MASK) rdata_o = WORD_W'(main_mask_q);
    if (addr_i == ADR_PER_MASK)  rdata_o = per_mask_rd;
    for (int w = 0; w < PRI_WORDS; w++) begin
      if (addr_i == ADDR_W'(ADR_PRI_BASE) + ADDR_W'(w)) rdata_o = pri_word[w];
    end
  end
endmodule

// File: rtl/irq_boost_split.sv
module irq_boost_split
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_PER = 24
) (
  input  logic [NUM_PER-1:0]             pend_i,
  input  logic [NUM_PER-1:0][PRI_W-1:0]  pri_i,
  output logic [NUM_PER-1:0]             hi_o,
  output logic [NUM_PER-1:0]             med_o
);
  for (genvar n = 0; n < NUM_PER; n++) begin : g_cls
    assign hi_o[n]  = pend_i[n] && (pri_i[n] == PRI_HIGH);
    assign med_o[n] = pend_i[n] && (pri_i[n] == PRI_MEDIUM);
  end
endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_PER = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CRIT_N-1:0]    crit_req_i,
  input  logic [MAIN_N-1:0]    main_req_i,
  input  logic [NUM_PER-1:0]   per_req_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic [WORD_W-1:0]    status_o
);
  logic [MAIN_N-1:0]             main_en;
  logic [NUM_PER-1:0]            per_en;
  logic [NUM_PER-1:0][PRI_W-1:0] per_pri;
  logic [CRIT_N-1:0]             crit_live;
  logic [MAIN_N-1:0]             main_live;
  logic [NUM_PER-1:0]            per_live, per_hi, per_med;
  logic                          crit_vld, main_vld, all_vld, hi_vld, med_vld;
  logic [IDX_W-1:0]              crit_idx, main_idx, all_idx, hi_idx, med_idx;
  grp_t                          crit_g, main_g, per_g;
  logic [WORD_W-1:0]             status_q;

  irq_reg_bank #(.NUM_PER(NUM_PER)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (status_q),
    .rdata_o   (reg_rdata_o),
    .main_en_o (main_en),
    .per_en_o  (per_en),
    .per_pri_o (per_pri)
  );

  // reserved codes are never produced by genuine sources
  always_comb begin
    crit_live = crit_req_i;
    crit_live[CRIT_BOOST] = 1'b0;
    main_live = main_req_i & main_en;
    main_live[MAIN_BOOST] = 1'b0;
    per_live  = per_req_i & per_en;
  end

  irq_boost_split #(.NUM_PER(NUM_PER)) u_split (
    .pend_i (per_live),
    .pri_i  (per_pri),
    .hi_o   (per_hi),
    .med_o  (per_med)
  );

  irq_prio_enc #(.N(CRIT_N), .OUT_W(IDX_W)) u_enc_crit (
    .req_i (crit_live), .vld_o (crit_vld), .idx_o (crit_idx)
  );
  irq_prio_enc #(.N(MAIN_N), .OUT_W(IDX_W)) u_enc_main (
    .req_i (main_live), .vld_o (main_vld), .idx_o (main_idx)
  );
  irq_prio_enc #(.N(NUM_PER), .OUT_W(IDX_W)) u_enc_all (
    .req_i (per_live), .vld_o (all_vld), .idx_o (all_idx)
  );
  irq_prio_enc #(.N(NUM_PER), .OUT_W(IDX_W)) u_enc_hi (
    .req_i (per_hi), .vld_o (hi_vld), .idx_o (hi_idx)
  );
  irq_prio_enc #(.N(NUM_PER), .OUT_W(IDX_W)) u_enc_med (
    .req_i (per_med), .vld_o (med_vld), .idx_o (med_idx)
  );

  always_comb begin
    crit_g = '0;
    if (crit_vld)    crit_g = '{vld: 1'b1, idx: crit_idx};
    else if (hi_vld) crit_g = '{vld: 1'b1, idx: IDX_W'(CRIT_BOOST)};

    main_g = '0;
    if (main_vld)                main_g = '{vld: 1'b1, idx: main_idx};
    else if (med_vld && !hi_vld) main_g = '{vld: 1'b1, idx: IDX_W'(MAIN_BOOST)};

    per_g = '0;
    if (hi_vld)       per_g = '{vld: 1'b1, idx: hi_idx};
    else if (med_vld) per_g = '{vld: 1'b1, idx: med_idx};
    else if (all_vld) per_g = '{vld: 1'b1, idx: all_idx};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= pack_status(crit_g, main_g, per_g);
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_PER = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [WORD_W-1:0]   status_i,
  input logic [CRIT_N-1:0]   crit_req_i,
  input logic [MAIN_N-1:0]   main_req_i,
  input logic [NUM_PER-1:0]  per_req_i,
  input logic [MAIN_N-1:0]   main_en_i,
  input logic [NUM_PER-1:0]  per_en_i
);
  logic [CRIT_N-1:0]  p_crit;
  logic [MAIN_N-1:0]  p_main, p_main_en;
  logic [NUM_PER-1:0] p_per, p_per_en;
  logic [CRIT_W-1:0]  c_idx;
  logic [IDX_W-1:0]   m_idx, q_idx;
  logic               c_hit, m_hit, q_hit, p_quiet, main_none;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_crit <= '0; p_main <= '0; p_main_en <= '0; p_per <= '0; p_per_en <= '0;
    end else begin
      p_crit <= crit_req_i; p_main <= main_req_i; p_main_en <= main_en_i;
      p_per <= per_req_i; p_per_en <= per_en_i;
    end
  end

  always_comb begin
    c_idx = status_i[CRIT_LSB +: CRIT_W];
    m_idx = status_i[MAIN_LSB +: IDX_W];
    q_idx = status_i[PER_LSB +: IDX_W];
    c_hit = p_crit[c_idx];
    m_hit = 1'b0;
    for (int i = 0; i < MAIN_N; i++) if (m_idx == IDX_W'(i)) m_hit = p_main[i] & p_main_en[i];
    q_hit = 1'b0;
    for (int i = 0; i < NUM_PER; i++) if (q_idx == IDX_W'(i)) q_hit = p_per[i] & p_per_en[i];
    main_none = ((p_main & p_main_en) & ~(MAIN_N'(1) << MAIN_BOOST)) == '0;
    p_quiet = (p_crit == '0) && (p_main == '0) && (p_per == '0);
  end

  a_r11_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[31:30] == '0) && (status_i[23:22] == '0) && (status_i[15:11] == '0) && (status_i[7:0] == '0));

  a_r11_empty_field_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_i[CRIT_VLD] |-> c_idx == '0) and (!status_i[MAIN_VLD] |-> m_idx == '0)
    and (!status_i[PER_VLD] |-> q_idx == '0));

  a_r2_crit_genuine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[CRIT_VLD] && c_idx != CRIT_W'(CRIT_BOOST) |-> c_hit);

  a_r8_crit_boost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[CRIT_VLD] && c_idx == CRIT_W'(CRIT_BOOST) |->
      status_i[PER_VLD] && (p_crit & ~(CRIT_N'(1) << CRIT_BOOST)) == '0);

  a_r5_main_genuine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[MAIN_VLD] && m_idx != IDX_W'(MAIN_BOOST) |-> m_hit);

  a_r9_main_boost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[MAIN_VLD] && m_idx == IDX_W'(MAIN_BOOST) |-> status_i[PER_VLD] && main_none);

  a_r6_per_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[PER_VLD] |-> q_hit);

  a_r12_quiet_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_quiet |-> status_i == '0);
endmodule

bind irq_status_enc irq_status_chk #(.NUM_PER(NUM_PER)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_o),
  .crit_req_i (crit_req_i),
  .main_req_i (main_req_i),
  .per_req_i  (per_req_i),
  .main_en_i  (main_en),
  .per_en_i   (per_en)
);

// File: tb/irq_status_enc_tb_top.sv
module irq_status_enc_tb_top;
  localparam int NP = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    crit_req_i = '0;
  logic [16:0]   main_req_i = '0;
  logic [NP-1:0] per_req_i = '0;
  logic [2:0]    reg_addr_i = '0;
  logic          reg_we_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o, status_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  bit [31:0] m_mask = 32'h0001_0fff;
  bit [31:0] p_mask = 32'h7fff_fc00;
  int        pri [NP];
  bit [31:0] exp_q = '0;

  always #2 clk_i = ~clk_i;

  irq_status_enc #(.NUM_PER(NP)) dut_i (
    .clk_i, .rst_ni, .crit_req_i, .main_req_i, .per_req_i,
    .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .status_o
  );

  function automatic bit [31:0] ref_status();
    bit [31:0] s = '0;
    int c = -1, m = -1, h = -1, md = -1, a = -1;
    for (int i = 0; i < 4; i++) if (c < 0 && i != 2 && crit_req_i[i]) c = i;
    for (int i = 0; i < 17; i++) if (m < 0 && i != 4 && main_req_i[i] && !m_mask[16-i]) m = i;
    for (int i = 0; i < NP; i++) begin
      if (per_req_i[i] && !p_mask[31-i]) begin
        if (a < 0) a = i;
        if (h < 0 && pri[i] == 2) h = i;
        if (md < 0 && pri[i] == 1) md = i;
      end
    end
    if (c >= 0) s |= 32'h400 | (32'(c) << 8);
    else if (h >= 0) s |= 32'h600;
    if (m >= 0) s |= 32'h0020_0000 | (32'(m) << 16);
    else if (md >= 0 && h < 0) s |= 32'h0024_0000;
    if (h >= 0) s |= 32'h2000_0000 | (32'(h) << 24);
    else if (md >= 0) s |= 32'h2000_0000 | (32'(md) << 24);
    else if (a >= 0) s |= 32'h2000_0000 | (32'(a) << 24);
    return s;
  endfunction

  function automatic bit [31:0] ref_read(int adr);
    bit [31:0] r = '0;
    case (adr)
      0: r = exp_q;
      1: r = m_mask;
      2: r = p_mask;
      3: for (int n = 0; n < 16; n++) r |= 32'(pri[n]) << (2*n);
      4: for (int n = 16; n < NP; n++) r |= 32'(pri[n]) << (2*(n-16));
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_q = ref_status();
      if (reg_we_i) begin
        case (int'(reg_addr_i))
          1: m_mask = reg_wdata_i & 32'h0001_ffff;
          2: p_mask = reg_wdata_i & 32'hffff_ff00;
          3: for (int n = 0; n < 16; n++) pri[n] = int'((reg_wdata_i >> (2*n)) & 3);
          4: for (int n = 16; n < NP; n++) pri[n] = int'((reg_wdata_i >> (2*(n-16))) & 3);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R12)
  always @(negedge clk_i) if (rst_ni && !done) chk("R12 status vs model", status_o, exp_q);

  task automatic wr(int adr, bit [31:0] d);
    @(negedge clk_i);
    reg_addr_i = 3'(adr); reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(string tag, int adr, bit [31:0] exp);
    reg_addr_i = 3'(adr);
    #1;
    chk(tag, reg_rdata_o, exp);
    chk({tag, " model"}, reg_rdata_o, ref_read(adr));
  endtask

  task automatic apply(bit [3:0] c, bit [16:0] m, bit [NP-1:0] p);
    crit_req_i = c; main_req_i = m; per_req_i = p;
    @(negedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int n = 0; n < NP; n++) pri[n] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk("R1 status after reset", status_o, 32'h0);
    rd("R1 main mask reset", 1, 32'h0001_0fff);
    rd("R1 per mask reset", 2, 32'h7fff_fc00);
    rd("R1 pri lo reset", 3, 32'h0);
    rd("R1 pri hi reset", 4, 32'h0);

    apply('0, '0, '0);             chk("R11 idle status", status_o, 32'h0);
    apply(4'b1010, '0, '0);        chk("R2 lowest critical", status_o, 32'h0000_0500);
    apply(4'b0100, '0, '0);        chk("R2 source 2 ignored", status_o, 32'h0);
    apply('0, 17'h0000c, '0);      chk("R3 lowest main", status_o, 32'h0022_0000);
    apply('0, 17'h00080, '0);      chk("R5 masked main source", status_o, 32'h0);
    wr(1, 32'h0);
    apply('0, 17'h00080, '0);      chk("R5 unmasked main source", status_o, 32'h0027_0000);
    apply('0, 17'h00010, '0);      chk("R3 source 4 ignored", status_o, 32'h0);
    apply('0, '0, 24'h000020);     chk("R6 masked per source", status_o, 32'h0);
    apply('0, '0, 24'h400000);     chk("R4 per field", status_o, 32'h3600_0000);
    wr(2, 32'h7bff_fc00);
    rd("R6 per mask readback", 2, 32'h7bff_fc00);
    apply('0, '0, 24'h000020);     chk("R6 unmasked per source", status_o, 32'h2500_0000);

    wr(4, 32'h0000_2000);          // source 22 high
    apply('0, '0, 24'h400001);     chk("R8 high boost", status_o, 32'h3600_0600);
    apply(4'b0001, '0, 24'h400001); chk("R8 genuine critical first", status_o, 32'h3600_0400);
    wr(4, 32'h0000_6000);          // 23 medium
    rd("R7 pri hi readback", 4, 32'h0000_6000);
    apply('0, '0, 24'h800001);     chk("R9 medium boost", status_o, 32'h3724_0000);
    apply('0, 17'h2, 24'h800001);  chk("R9 genuine main first", status_o, 32'h3721_0000);
    apply('0, '0, 24'hc00001);     chk("R10 high over medium", status_o, 32'h3600_0600);
    wr(3, 32'h0000_0c00);          // source 5 code 3
    apply('0, '0, 24'h000021);     chk("R7 code 3 normal", status_o, 32'h2000_0000);
    wr(2, 32'h7bff_fe00);          // mask 22
    apply('0, '0, 24'h400000);     chk("R6 masked high no boost", status_o, 32'h0);

    apply('0, '0, '0);
    wr(0, 32'hffff_ffff);
    rd("R13 status write ignored", 0, 32'h0);
    rd("R13 main mask untouched", 1, 32'h0);
    wr(5, 32'hffff_ffff);
    rd("R13 unused address", 5, 32'h0);
    rd("R13 pri lo intact", 3, 32'h0000_0c00);
    wr(4, 32'hffff_ffff);          rd("R7 pri hi width", 4, 32'h0000_ffff);
    wr(1, 32'hffff_ffff);          rd("R5 main mask width", 1, 32'h0001_ffff);
    wr(2, 32'hffff_ffff);          rd("R6 per mask width", 2, 32'hffff_ff00);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_i);
      crit_req_i = 4'($urandom);
      main_req_i = 17'($urandom & $urandom);
      per_req_i  = NP'($urandom & $urandom & $urandom);
      reg_we_i   = ($urandom % 6) == 0;
      reg_addr_i = 3'($urandom % 6);
      reg_wdata_i = ($urandom % 3 == 0) ? 32'h0 : ($urandom & $urandom);
      #1;
      chk("R13 random read", reg_rdata_o, ref_read(int'(reg_addr_i)));
    end
    @(negedge clk_i);
    reg_we_i = 1'b0;
    @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule